// File: doc/BRIEF.md
# TDM Slot-Mapped Serial Audio Port

This block is the master side of a frame-based synchronous serial link for audio. It generates a bit clock and a frame sync, shifts out transmit words and shifts in receive words. The frame is divided into 16-bit time slots numbered from zero. A frame holds two slots (32 bits) or four slots (64 bits). Four transmit channels (left, right and two control-data channels) each take a word from a parallel holding register. Four receive channels each hand a captured word back over a parallel strobe. Every channel has its own enable and its own 4-bit slot number. The left and right channels have separate slot numbers for transmit and receive. Each control-data channel uses one slot number for both directions.

The bit clock runs at half the core clock. A polarity input chooses which bit-clock edge samples the receive line. Transmit data always changes on the other edge. A sync-style input selects one of two sync shapes. In pulse mode the sync is a one-bit marker. In left/right mode the sync is a level that is high for the left half of the frame. In both modes there is no bit delay: the sync starts together with the most significant bit of slot 0.

Top module: `tdm_slot_port`

## Requirements
- R1: A frame code of 4'b1100 selects a 32-bit frame (slots 0 and 1). Every other code selects a 64-bit frame (slots 0 to 3). The frame repeats with no gap.
- R2: One bit lasts two core clocks. `sck_o` is low in the first half of each bit when `rx_fall_i`=0 and high when `rx_fall_i`=1. `rxd_i` is sampled at the mid-bit edge (rising for `rx_fall_i`=0, falling for 1). `txd_o` and `fsync_o` change only at the bit-start edge.
- R3: With `sync_lr_i`=0, `fsync_o` is high for exactly bit 0 of each frame, together with the MSB of slot 0.
- R4: With `sync_lr_i`=1, `fsync_o` is high for the first half of the frame (left) and low for the second half (right).
- R5: Transmit channel index 0=left, 1=right, 2=control 0, 3=control 1. The word for channel i sits on `tx_word_i[16i+15:16i]` and is latched by `tx_wr_i[i]`. At the first bit of a slot the matching channel's held word is loaded and sent MSB first. `tx_load_o[i]` pulses for one clock at that bit.
- R6: If no new word was written, the channel repeats its previously held word in later frames.
- R7: `txd_o` is 0 for all bits of a slot that has no enabled transmit channel. A disabled channel occupies no slot, whatever its slot number.
- R8: At the last bit of a slot, the matching enabled receive channel raises `rx_valid_o[i]` (same index order as R5) for one clock. `rx_data_o` then carries the 16 bits received in that slot, the first bit received as MSB.
- R9: Transmit and receive slot numbers of the same channel are independent. For example, left transmit in slot 0, left receive in slot 1, right transmit in slot 2 and right receive in slot 3 all work in one frame.
- R10: A channel whose slot number is not below the frame's slot count (2 or 4) never transmits and never strobes.
- R11: When several enabled channels of one direction name the same slot, the lowest channel index takes it.
- R12: At most one bit of `tx_load_o` and at most one bit of `rx_valid_o` is high in any cycle.
- R13: While `rst_ni` is low, `txd_o`, `fsync_o`, `tx_load_o` and `rx_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_code_i | input | 4 | Frame length code |
| rx_fall_i | input | 1 | Receive sampling edge select (0 rising, 1 falling) |
| sync_lr_i | input | 1 | Sync style (0 pulse, 1 left/right level) |
| tx_en_i | input | 2 | Transmit enables, bit0 left, bit1 right |
| tx_slot_i | input | 8 | Transmit slot numbers, [3:0] left, [7:4] right |
| rx_en_i | input | 2 | Receive enables, bit0 left, bit1 right |
| rx_slot_i | input | 8 | Receive slot numbers, [3:0] left, [7:4] right |
| cd_en_i | input | 2 | Control-data channel enables |
| cd_slot_i | input | 8 | Control-data slot numbers, [3:0] channel 0 |
| tx_wr_i | input | 4 | Holding-register write strobes per transmit channel |
| tx_word_i | input | 64 | Words to hold, 16 bits per channel |
| tx_load_o | output | 4 | One-cycle strobe when a channel's word enters the shifter |
| rx_valid_o | output | 4 | One-cycle strobe per receive channel |
| rx_data_o | output | 16 | Received word, valid with `rx_valid_o` |
| sck_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |

## Verification
The bench sweeps both frame lengths, both sampling edges and both sync styles over four slot maps. The maps cover plain stereo, split transmit/receive slots, slot collisions, disabled channels holding live slot numbers, and out-of-range slot numbers. A design with an off-by-one slot boundary would shift words by a bit or strobe one bit early. A design with the wrong collision priority would send the control word where the left word belongs. A design that ignored the enables or the frame length would drive data into slots that must stay silent. Each frame's serial stream is compared bit by bit, and the repeat frame shows whether a stale or cleared holding register leaks out.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int CH_N   = 4;
    localparam int SLOT_W = 4;
    localparam logic [3:0] FL_CODE_SHORT = 4'b1100;
    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/tdm_timing.sv
module tdm_timing #(
    parameter int DATA_W = 16,
    localparam int LONG_BITS = 4 * DATA_W,
    localparam int BIT_W = $clog2(LONG_BITS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             short_i,
    input  logic             sync_lr_i,
    input  logic             rx_fall_i,
    output logic             phase_o,
    output logic [BIT_W-1:0] cur_bit_o,
    output logic [BIT_W-1:0] next_bit_o,
    output logic             sck_o,
    output logic             fsync_o
);
    localparam logic [BIT_W-1:0] LAST_LONG  = BIT_W'(LONG_BITS - 1);
    localparam logic [BIT_W-1:0] LAST_SHORT = BIT_W'(2 * DATA_W - 1);
    localparam logic [BIT_W-1:0] HALF_LONG  = BIT_W'(2 * DATA_W);
    localparam logic [BIT_W-1:0] HALF_SHORT = BIT_W'(DATA_W);

    typedef struct packed {
        logic             ph;
        logic [BIT_W-1:0] bitc;
        logic             fs;
    } tim_t;

    tim_t             st_d, st_q;
    logic [BIT_W-1:0] last_bit, half_bit, nbit;

    always_comb begin
        last_bit = short_i ? LAST_SHORT : LAST_LONG;
        half_bit = short_i ? HALF_SHORT : HALF_LONG;
        nbit     = (st_q.bitc >= last_bit) ? '0 : st_q.bitc + 1'b1;
        st_d     = st_q;
        st_d.ph  = ~st_q.ph;
        if (st_q.ph) begin
            st_d.bitc = nbit;
            st_d.fs   = sync_lr_i ? (nbit < half_bit) : (nbit == '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ph   <= 1'b1;
            st_q.bitc <= LAST_LONG;
            st_q.fs   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o    = st_q.ph;
    assign cur_bit_o  = st_q.bitc;
    assign next_bit_o = nbit;
    assign sck_o      = st_q.ph ^ rx_fall_i;
    assign fsync_o    = st_q.fs;
endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map
    import tdm_pkg::*;
(
    input  slot_t                   slot_i,
    input  logic [CH_N-1:0]         en_i,
    input  logic [CH_N*SLOT_W-1:0]  sel_i,
    output logic [CH_N-1:0]         win_o
);
    logic [CH_N-1:0] match;

    for (genvar g = 0; g < CH_N; g++) begin : g_match
        assign match[g] = en_i[g] && (sel_i[g*SLOT_W +: SLOT_W] == slot_i);
    end

    always_comb begin
        logic taken;
        taken = 1'b0;
        win_o = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (match[i] && !taken) begin
                win_o[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
    import tdm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     launch_i,
    input  logic                     start_i,
    input  logic [CH_N-1:0]          win_i,
    input  logic [CH_N-1:0]          wr_i,
    input  logic [CH_N*DATA_W-1:0]   word_i,
    output logic                     txd_o,
    output logic [CH_N-1:0]          load_o
);
    typedef struct packed {
        logic [CH_N-1:0][DATA_W-1:0] hold;
        logic [DATA_W-1:0]           sh;
        logic                        act;
        logic                        txd;
        logic [CH_N-1:0]             load;
    } tx_t;

    tx_t               st_d, st_q;
    logic [DATA_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (win_i[i]) pick = pick | st_q.hold[i];
        end
        st_d      = st_q;
        st_d.load = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (wr_i[i]) st_d.hold[i] = word_i[i*DATA_W +: DATA_W];
        end
        if (launch_i) begin
            if (start_i) begin
                if (|win_i) begin
                    st_d.act  = 1'b1;
                    st_d.txd  = pick[DATA_W-1];
                    st_d.sh   = pick << 1;
                    st_d.load = win_i;
                end else begin
                    st_d.act = 1'b0;
                    st_d.txd = 1'b0;
                    st_d.sh  = '0;
                end
            end else begin
                st_d.txd = st_q.act & st_q.sh[DATA_W-1];
                st_d.sh  = st_q.sh << 1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign txd_o  = st_q.txd;
    assign load_o = st_q.load;
endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
    import tdm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sample_i,
    input  logic              end_i,
    input  logic [CH_N-1:0]   win_i,
    input  logic              rxd_i,
    output logic [CH_N-1:0]   valid_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] data;
        logic [CH_N-1:0]   valid;
    } rx_t;

    rx_t               st_d, st_q;
    logic [DATA_W-1:0] word;

    always_comb begin
        word       = {st_q.sh[DATA_W-2:0], rxd_i};
        st_d       = st_q;
        st_d.valid = '0;
        if (sample_i) begin
            st_d.sh = word;
            if (end_i && (|win_i)) begin
                st_d.valid = win_i;
                st_d.data  = word;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign data_o  = st_q.data;
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
    import tdm_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int NCH = CH_N,
    localparam int SLOT_BITS = 2 * SLOT_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [3:0]            frame_code_i,
    input  logic                  rx_fall_i,
    input  logic                  sync_lr_i,
    input  logic [1:0]            tx_en_i,
    input  logic [SLOT_BITS-1:0]  tx_slot_i,
    input  logic [1:0]            rx_en_i,
    input  logic [SLOT_BITS-1:0]  rx_slot_i,
    input  logic [1:0]            cd_en_i,
    input  logic [SLOT_BITS-1:0]  cd_slot_i,
    input  logic [NCH-1:0]        tx_wr_i,
    input  logic [NCH*DATA_W-1:0] tx_word_i,
    output logic [NCH-1:0]        tx_load_o,
    output logic [NCH-1:0]        rx_valid_o,
    output logic [DATA_W-1:0]     rx_data_o,
    output logic                  sck_o,
    output logic                  fsync_o,
    output logic                  txd_o,
    input  logic                  rxd_i
);
    localparam int BIT_W  = $clog2(4 * DATA_W);
    localparam int DW_LOG = $clog2(DATA_W);

    logic             short_frame;
    logic             phase;
    logic [BIT_W-1:0] cur_bit, next_bit;
    slot_t            tx_slot_idx, rx_slot_idx;
    logic [NCH-1:0]   tx_win, rx_win;
    logic             tx_start, rx_end;

    assign short_frame = (frame_code_i == FL_CODE_SHORT);

    tdm_timing #(.DATA_W(DATA_W)) u_timing (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .short_i    (short_frame),
        .sync_lr_i  (sync_lr_i),
        .rx_fall_i  (rx_fall_i),
        .phase_o    (phase),
        .cur_bit_o  (cur_bit),
        .next_bit_o (next_bit),
        .sck_o      (sck_o),
        .fsync_o    (fsync_o)
    );

    assign tx_slot_idx = slot_t'(next_bit[BIT_W-1:DW_LOG]);
    assign rx_slot_idx = slot_t'(cur_bit[BIT_W-1:DW_LOG]);
    assign tx_start    = phase && (next_bit[DW_LOG-1:0] == '0);
    assign rx_end      = &cur_bit[DW_LOG-1:0];

    tdm_slot_map u_tx_map (
        .slot_i (tx_slot_idx),
        .en_i   ({cd_en_i, tx_en_i}),
        .sel_i  ({cd_slot_i, tx_slot_i}),
        .win_o  (tx_win)
    );

    tdm_slot_map u_rx_map (
        .slot_i (rx_slot_idx),
        .en_i   ({cd_en_i, rx_en_i}),
        .sel_i  ({cd_slot_i, rx_slot_i}),
        .win_o  (rx_win)
    );

    tdm_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .launch_i (phase),
        .start_i  (tx_start),
        .win_i    (tx_win),
        .wr_i     (tx_wr_i),
        .word_i   (tx_word_i),
        .txd_o    (txd_o),
        .load_o   (tx_load_o)
    );

    tdm_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sample_i (!phase),
        .end_i    (rx_end),
        .win_i    (rx_win),
        .rxd_i    (rxd_i),
        .valid_o  (rx_valid_o),
        .data_o   (rx_data_o)
    );
endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk #(
    parameter int DATA_W = 16,
    parameter int NCH = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rx_fall_i,
    input logic              sck_o,
    input logic              fsync_o,
    input logic              txd_o,
    input logic [NCH-1:0]    tx_load_o,
    input logic [NCH-1:0]    rx_valid_o,
    input logic [DATA_W-1:0] rx_data_o
);
    logic mid;
    assign mid = sck_o ^ rx_fall_i;

    assert_clk_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mid |=> mid);
    assert_clk_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mid |=> !mid);
    assert_txd_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(txd_o) |-> !mid);
    assert_fsync_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(fsync_o) |-> !mid);
    assert_valid_at_sample_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rx_valid_o) |-> mid);
    assert_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rx_valid_o) |=> (rx_valid_o == '0));
    assert_data_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(rx_data_o) |-> (|rx_valid_o));
    assert_load_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(tx_load_o));
    assert_valid_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(rx_valid_o));
endmodule

bind tdm_slot_port tdm_slot_port_chk #(.DATA_W(DATA_W), .NCH(NCH)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_fall_i  (rx_fall_i),
    .sck_o      (sck_o),
    .fsync_o    (fsync_o),
    .txd_o      (txd_o),
    .tx_load_o  (tx_load_o),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o)
);

// File: tb/tdm_slot_port_tb.sv
`timescale 1ns/1ps
module tdm_slot_port_tb;
    localparam int DW = 16;
    localparam int CH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    frame_code = 4'b1101;
    logic          rx_fall = 1'b0, sync_lr = 1'b0;
    logic [1:0]    tx_en = '0, rx_en = '0, cd_en = '0;
    logic [7:0]    tx_slot = '0, rx_slot = '0, cd_slot = '0;
    logic [CH-1:0] tx_wr = '0;
    logic [CH*DW-1:0] tx_word = '0;
    logic [CH-1:0] tx_load, rx_valid;
    logic [DW-1:0] rx_data;
    logic          sck, fsync, txd;
    logic          rxd = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;
    int te[CH], ts[CH], re[CH], rs[CH];
    logic [DW-1:0] words[CH];

    always #5 clk = ~clk;

    tdm_slot_port u_dut (
        .clk_i(clk), .rst_ni(rst_n), .frame_code_i(frame_code),
        .rx_fall_i(rx_fall), .sync_lr_i(sync_lr),
        .tx_en_i(tx_en), .tx_slot_i(tx_slot), .rx_en_i(rx_en), .rx_slot_i(rx_slot),
        .cd_en_i(cd_en), .cd_slot_i(cd_slot), .tx_wr_i(tx_wr), .tx_word_i(tx_word),
        .tx_load_o(tx_load), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .sck_o(sck), .fsync_o(fsync), .txd_o(txd), .rxd_i(rxd)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int winner(bit tx, int s);
        for (int i = 0; i < CH; i++) begin
            if (tx && te[i] != 0 && ts[i] == s) return i;
            if (!tx && re[i] != 0 && rs[i] == s) return i;
        end
        return -1;
    endfunction

    function automatic logic [DW-1:0] rx_pat(int f, int s, int idx);
        return 16'hC35A ^ 16'(f * 16'h0101) ^ 16'(s * 16'h1E1E) ^ 16'(idx * 7);
    endfunction

    task automatic set_map(int m);
        case (m)
            0: begin tx_en = 2'b11; tx_slot = 8'h10; rx_en = 2'b11; rx_slot = 8'h10;
                     cd_en = 2'b00; cd_slot = 8'h00; end
            1: begin tx_en = 2'b11; tx_slot = 8'h20; rx_en = 2'b11; rx_slot = 8'h31;
                     cd_en = 2'b00; cd_slot = 8'h00; end
            2: begin tx_en = 2'b01; tx_slot = 8'h01; rx_en = 2'b11; rx_slot = 8'h50;
                     cd_en = 2'b11; cd_slot = 8'h01; end
            default: begin tx_en = 2'b00; tx_slot = 8'h21; rx_en = 2'b00; rx_slot = 8'h10;
                     cd_en = 2'b10; cd_slot = 8'h30; end
        endcase
        te[0] = int'(tx_en[0]); te[1] = int'(tx_en[1]); te[2] = int'(cd_en[0]); te[3] = int'(cd_en[1]);
        re[0] = int'(rx_en[0]); re[1] = int'(rx_en[1]); re[2] = int'(cd_en[0]); re[3] = int'(cd_en[1]);
        ts[0] = int'(tx_slot[3:0]); ts[1] = int'(tx_slot[7:4]);
        ts[2] = int'(cd_slot[3:0]); ts[3] = int'(cd_slot[7:4]);
        rs[0] = int'(rx_slot[3:0]); rs[1] = int'(rx_slot[7:4]);
        rs[2] = ts[2]; rs[3] = ts[3];
    endtask

    task automatic run_cfg(int lng, int rf, int sl, int m, int idx);
        int fl;
        @(negedge clk);
        rst_n = 1'b0;
        frame_code = lng != 0 ? 4'b1101 : 4'b1100;
        rx_fall = rf[0];
        sync_lr = sl[0];
        set_map(m);
        for (int i = 0; i < CH; i++) begin
            words[i] = 16'((i + 1) * 16'h1357) ^ 16'(idx * 16'h0F0F) ^ 16'h8000;
            tx_word[i*DW +: DW] = words[i];
        end
        @(negedge clk);
        check(txd == 1'b0 && fsync == 1'b0, "R13", "txd/fsync in reset", {txd, fsync}, 0);
        check(tx_load == '0 && rx_valid == '0, "R13", "strobes in reset", {tx_load, rx_valid}, 0);
        fl = lng != 0 ? 64 : 32;
        tx_wr = '1;
        rst_n = 1'b1;
        for (int g = 0; g < 3 * fl; g++) begin
            int f, k, s, b, w, rw;
            logic [CH-1:0] exp_load, exp_valid;
            logic exp_fs, exp_txd;
            string tag;
            logic [DW-1:0] pat;
            f = g / fl; k = g % fl; s = k / DW; b = k % DW;
            @(posedge clk); @(negedge clk);
            if (g == 0) tx_wr = '0;
            check(sck == rf[0], "R2", "sck at bit start", sck, rf);
            exp_fs = sl != 0 ? (k < fl / 2) : (k == 0);
            check(fsync == exp_fs, sl != 0 ? "R4" : "R1,R3", "fsync", fsync, exp_fs);
            w = winner(1, s);
            exp_load = (b == 0 && w >= 0) ? CH'(1 << w) : '0;
            check(tx_load == exp_load, "R12", "tx_load", tx_load, exp_load);
            if (f >= 1) begin
                exp_txd = w >= 0 ? words[w][DW-1-b] : 1'b0;
                tag = m == 2 ? "R11" : (w < 0 ? ((m == 1 && lng == 0) ? "R10" : "R7")
                                              : (f == 2 ? "R6" : "R5"));
                check(txd == exp_txd, tag, $sformatf("txd bit %0d frame %0d", k, f), txd, exp_txd);
            end
            pat = rx_pat(f, s, idx);
            rxd = pat[DW-1-b];
            @(posedge clk); @(negedge clk);
            check(sck == !rf[0], "R2", "sck at mid bit", sck, !rf[0]);
            rw = winner(0, s);
            exp_valid = (b == DW - 1 && rw >= 0) ? CH'(1 << rw) : '0;
            tag = (m == 2 || (m == 1 && lng == 0)) ? "R10" : "R8";
            check(rx_valid == exp_valid, tag, $sformatf("rx_valid bit %0d", k), rx_valid, exp_valid);
            if (exp_valid != '0)
                check(rx_data == pat, m == 1 ? "R9" : "R8", "rx_data", rx_data, pat);
        end
    endtask

    initial begin
        int idx;
        idx = 0;
        for (int lng = 0; lng < 2; lng++)
            for (int rf = 0; rf < 2; rf++)
                for (int sl = 0; sl < 2; sl++)
                    for (int m = 0; m < 4; m++) begin
                        run_cfg(lng, rf, sl, m, idx);
                        idx++;
                    end
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule